// File: doc/BRIEF.md
# Two-Channel Disk Interrupt Status Block

This block holds the interrupt bookkeeping for a host controller that serves two parallel disk channels. Each channel has a drive interrupt line. A rising edge on that line latches a pending flag and the interrupt bit of that channel's bus-master status byte. The pending flag can be read in two places: a per-channel configuration byte and a shared mirror byte. Software can clear it from either place by writing a one. A write that carries a zero in the flag's position leaves the flag alone, so a read-modify-write of the surrounding configuration bits cannot lose an interrupt.

The mirror byte also holds one block bit per channel. A blocked channel keeps its pending flag but does not drive the shared interrupt output. Each channel has a bus-master status byte with write-one-to-clear interrupt and error bits, and a command byte whose bit 0 starts or stops the transfer. A select input picks a channel. The source-hit output then reports whether that channel is really the interrupt source, meaning both its pending flag and its status interrupt bit are set.

Top module: `ide_irq_regs`

## Requirements
- R1: After reset, every pending flag, block bit, status bit, run bit and stored configuration bit is zero, so `irq_out`, `src_hit` and `dma_run` are low.
- R2: A rising edge on `irq_in[c]` sets channel c's pending flag and its status interrupt bit (bit 2) on the next clock. Holding the line high does not set either of them again after it has been cleared.
- R3: Channel 0's pending flag reads at address 0x50 bit 2 and at 0x71 bit 2. Channel 1's pending flag reads at 0x57 bit 4 and at 0x71 bit 3.
- R4: Writing 0x50 with bit 2 set clears channel 0's flag, and writing 0x57 with bit 4 set clears channel 1's flag. A zero in that position leaves the flag unchanged. The other seven bits of each of these bytes are plain read/write storage.
- R5: Writing 0x71 with bit 2 or bit 3 set clears the pending flag of channel 0 or channel 1 respectively. Bits 0, 1, 6 and 7 of 0x71 read zero.
- R6: Bits 4 and 5 of 0x71 are the read/write block bits of channels 0 and 1. `irq_out` is high exactly when some channel has its pending flag set and its block bit clear.
- R7: The status bytes at 0x72 (channel 0) and 0x7A (channel 1) hold the interrupt flag in bit 2, the error flag in bit 1 and the run bit in bit 0, with bits 7..3 reading zero. A high `err_in[c]` sets the error flag. Writing a one to bit 1 or bit 2 clears that flag.
- R8: The command bytes at 0x70 and 0x78 hold the run bit in bit 0, and bits 7..1 read zero. A write loads it, so writing zero stops the transfer. `dma_run[c]` shows it.
- R9: `src_hit` is high exactly when the channel chosen by `chan_sel` has both its pending flag and its status interrupt bit set.
- R10: When a set event (an irq edge or `err_in`) and a clearing write to the same flag fall in one cycle, the flag ends up set.
- R11: Reads have no side effects. Addresses outside the map read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq_in | input | 2 | Drive interrupt lines, one per channel |
| err_in | input | 2 | Transfer error indications, one per channel |
| chan_sel | input | 1 | Channel that `src_hit` reports on |
| irq_out | output | 1 | Combined unblocked interrupt request |
| src_hit | output | 1 | Selected channel really raised its interrupt |
| dma_run | output | 2 | Run bits of the two command bytes |

## Verification
Directed sequences set and clear the pending flags through each of the two paths, and so separate a lost or cross-wired clear from a working one. They also hold an interrupt line high across a clear, which exposes level-triggered setting, and they write a zero in the flag's position, which exposes a clear that ignores the data bit. A set and a clear landing in one cycle separate the priority order from its reverse. With the block bits set, pending state stays visible in the registers while the shared output is held low. Random cycles then mix edges, errors, register writes and channel selects, and every mapped address plus one unmapped address is compared against a bench model after each cycle.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;

    localparam int NCH    = 2;
    localparam int BYTE_W = 8;

    // bit positions decoded by software
    localparam int CFG0_PEND_BIT = 2;
    localparam int CFG1_PEND_BIT = 4;
    localparam int MIR_PEND_LSB  = 2;
    localparam int MIR_BLK_LSB   = 4;
    localparam int ST_INTR_BIT   = 2;
    localparam int ST_ERR_BIT    = 1;
    localparam int CMD_RUN_BIT   = 0;

    typedef struct packed {
        logic prev;
        logic pend;
        logic blk;
        logic dintr;
        logic derr;
        logic run;
    } chan_st_t;

    typedef struct packed {
        logic [BYTE_W-1:0] cfg0;
        logic [BYTE_W-1:0] cfg1;
    } cfg_st_t;

endpackage

// File: rtl/ide_irq_chan.sv
module ide_irq_chan
    import ide_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_in,
    input  logic err_in,
    input  logic clr_pend,
    input  logic blk_we,
    input  logic blk_val,
    input  logic clr_intr,
    input  logic clr_err,
    input  logic cmd_we,
    input  logic cmd_run,
    output logic pend,
    output logic blk,
    output logic dintr,
    output logic derr,
    output logic run
);

    chan_st_t st_d, st_q;
    logic     rise;

    always_comb begin
        st_d      = st_q;
        rise      = irq_in && !st_q.prev;
        st_d.prev = irq_in;

        // set wins over a clear in the same cycle
        if (rise)          st_d.pend = 1'b1;
        else if (clr_pend) st_d.pend = 1'b0;

        if (rise)          st_d.dintr = 1'b1;
        else if (clr_intr) st_d.dintr = 1'b0;

        if (err_in)        st_d.derr = 1'b1;
        else if (clr_err)  st_d.derr = 1'b0;

        if (blk_we)        st_d.blk = blk_val;
        if (cmd_we)        st_d.run = cmd_run;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend  = st_q.pend;
    assign blk   = st_q.blk;
    assign dintr = st_q.dintr;
    assign derr  = st_q.derr;
    assign run   = st_q.run;

    a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in && !st_q.prev) |=> (pend && dintr));

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in && !st_q.prev && clr_pend) |=> pend);

    a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend && !(irq_in && !st_q.prev)) |=> !pend);

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_pend && !(irq_in && !st_q.prev)) |=> $stable(pend));

    a_r7_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
        err_in |=> derr);

    a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !cmd_run) |=> !run);

endmodule

// File: rtl/ide_irq_rdmux.sv
module ide_irq_rdmux
    import ide_irq_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] A_CFG0  = 8'h50,
    parameter logic [ADDR_W-1:0] A_CFG1  = 8'h57,
    parameter logic [ADDR_W-1:0] A_MIR   = 8'h71,
    parameter logic [ADDR_W-1:0] A_CMD0  = 8'h70,
    parameter logic [ADDR_W-1:0] A_ST0   = 8'h72,
    parameter logic [ADDR_W-1:0] A_CMD1  = 8'h78,
    parameter logic [ADDR_W-1:0] A_ST1   = 8'h7A
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] cfg0,
    input  logic [BYTE_W-1:0] cfg1,
    input  logic [NCH-1:0]    pend,
    input  logic [NCH-1:0]    blk,
    input  logic [NCH-1:0]    dintr,
    input  logic [NCH-1:0]    derr,
    input  logic [NCH-1:0]    run,
    output logic [BYTE_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CFG0: begin
                rdata                = cfg0;
                rdata[CFG0_PEND_BIT] = pend[0];
            end
            A_CFG1: begin
                rdata                = cfg1;
                rdata[CFG1_PEND_BIT] = pend[1];
            end
            A_MIR: begin
                rdata[MIR_PEND_LSB +: NCH] = pend;
                rdata[MIR_BLK_LSB  +: NCH] = blk;
            end
            A_CMD0: rdata[CMD_RUN_BIT] = run[0];
            A_CMD1: rdata[CMD_RUN_BIT] = run[1];
            A_ST0: begin
                rdata[ST_INTR_BIT] = dintr[0];
                rdata[ST_ERR_BIT]  = derr[0];
                rdata[CMD_RUN_BIT] = run[0];
            end
            A_ST1: begin
                rdata[ST_INTR_BIT] = dintr[1];
                rdata[ST_ERR_BIT]  = derr[1];
                rdata[CMD_RUN_BIT] = run[1];
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/ide_irq_regs.sv
module ide_irq_regs
    import ide_irq_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] A_CFG0 = 8'h50,
    parameter logic [ADDR_W-1:0] A_CFG1 = 8'h57,
    parameter logic [ADDR_W-1:0] A_MIR  = 8'h71,
    parameter logic [ADDR_W-1:0] A_CMD0 = 8'h70,
    parameter logic [ADDR_W-1:0] A_ST0  = 8'h72,
    parameter logic [ADDR_W-1:0] A_CMD1 = 8'h78,
    parameter logic [ADDR_W-1:0] A_ST1  = 8'h7A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [1:0]        irq_in,
    input  logic [1:0]        err_in,
    input  logic              chan_sel,
    output logic              irq_out,
    output logic              src_hit,
    output logic [1:0]        dma_run
);

    localparam logic [BYTE_W-1:0] CFG0_KEEP = ~(BYTE_W'(1) << CFG0_PEND_BIT);
    localparam logic [BYTE_W-1:0] CFG1_KEEP = ~(BYTE_W'(1) << CFG1_PEND_BIT);

    cfg_st_t cfg_d, cfg_q;

    logic wr_cfg0, wr_cfg1, wr_mir;
    logic [NCH-1:0] clr_pend, wr_st, wr_cmd;
    logic [NCH-1:0] pend, blk, dintr, derr, run;

    assign wr_cfg0 = wr_en && (addr == A_CFG0);
    assign wr_cfg1 = wr_en && (addr == A_CFG1);
    assign wr_mir  = wr_en && (addr == A_MIR);

    assign clr_pend[0] = (wr_cfg0 && wdata[CFG0_PEND_BIT]) ||
                         (wr_mir  && wdata[MIR_PEND_LSB]);
    assign clr_pend[1] = (wr_cfg1 && wdata[CFG1_PEND_BIT]) ||
                         (wr_mir  && wdata[MIR_PEND_LSB + 1]);

    assign wr_st[0]  = wr_en && (addr == A_ST0);
    assign wr_st[1]  = wr_en && (addr == A_ST1);
    assign wr_cmd[0] = wr_en && (addr == A_CMD0);
    assign wr_cmd[1] = wr_en && (addr == A_CMD1);

    always_comb begin
        cfg_d = cfg_q;
        if (wr_cfg0) cfg_d.cfg0 = wdata & CFG0_KEEP;
        if (wr_cfg1) cfg_d.cfg1 = wdata & CFG1_KEEP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        ide_irq_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_in   (irq_in[c]),
            .err_in   (err_in[c]),
            .clr_pend (clr_pend[c]),
            .blk_we   (wr_mir),
            .blk_val  (wdata[MIR_BLK_LSB + c]),
            .clr_intr (wr_st[c] && wdata[ST_INTR_BIT]),
            .clr_err  (wr_st[c] && wdata[ST_ERR_BIT]),
            .cmd_we   (wr_cmd[c]),
            .cmd_run  (wdata[CMD_RUN_BIT]),
            .pend     (pend[c]),
            .blk      (blk[c]),
            .dintr    (dintr[c]),
            .derr     (derr[c]),
            .run      (run[c])
        );
    end

    ide_irq_rdmux #(
        .ADDR_W (ADDR_W),
        .A_CFG0 (A_CFG0),
        .A_CFG1 (A_CFG1),
        .A_MIR  (A_MIR),
        .A_CMD0 (A_CMD0),
        .A_ST0  (A_ST0),
        .A_CMD1 (A_CMD1),
        .A_ST1  (A_ST1)
    ) u_rdmux (
        .addr  (addr),
        .cfg0  (cfg_q.cfg0),
        .cfg1  (cfg_q.cfg1),
        .pend  (pend),
        .blk   (blk),
        .dintr (dintr),
        .derr  (derr),
        .run   (run),
        .rdata (rdata)
    );

    assign irq_out = |(pend & ~blk);
    assign src_hit = pend[chan_sel] && dintr[chan_sel];
    assign dma_run = run;

    a_r6_all_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (blk == 2'b11) |-> !irq_out);

    a_r6_open_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend[0] && !blk[0]) || (pend[1] && !blk[1])) |-> irq_out);

    a_r9_hit_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        src_hit |-> (pend[chan_sel] && dintr[chan_sel]));

    a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CFG1 && !wdata[CFG1_PEND_BIT] && pend[1]) |=> pend[1]);

    a_r11_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_cfg0 && !wr_cfg1) |=> $stable(cfg_q));

endmodule

// File: tb/ide_irq_regs_test.sv
module ide_irq_regs_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [1:0] irq_in = 2'b00;
    logic [1:0] err_in = 2'b00;
    logic       chan_sel = 1'b0;
    logic       irq_out, src_hit;
    logic [1:0] dma_run;

    int total = 0;
    int bad   = 0;

    // bench model
    logic [1:0] m_prev, m_pend, m_blk, m_di, m_de, m_run;
    logic [7:0] m_cfg0, m_cfg1;

    always #(CLK_PERIOD/2) clk = ~clk;

    ide_irq_regs uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_in(irq_in), .err_in(err_in), .chan_sel(chan_sel),
        .irq_out(irq_out), .src_hit(src_hit), .dma_run(dma_run)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        logic [7:0] r;
        r = 8'h00;
        case (a)
            8'h50: r = m_cfg0 | {5'b0, m_pend[0], 2'b0};
            8'h57: r = m_cfg1 | {3'b0, m_pend[1], 4'b0};
            8'h71: r = {2'b0, m_blk, m_pend, 2'b0};
            8'h70: r = {7'b0, m_run[0]};
            8'h78: r = {7'b0, m_run[1]};
            8'h72: r = {5'b0, m_di[0], m_de[0], m_run[0]};
            8'h7A: r = {5'b0, m_di[1], m_de[1], m_run[1]};
            default: r = 8'h00;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h50, 8'h57: return "R4";
            8'h71:        return "R5";
            8'h70, 8'h78: return "R8";
            8'h72, 8'h7A: return "R7";
            default:      return "R11";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%02h expected=%02h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_prev = '0; m_pend = '0; m_blk = '0; m_di = '0; m_de = '0; m_run = '0;
        m_cfg0 = '0; m_cfg1 = '0;
    endtask

    // apply one clock with the inputs now driven, updating the model
    task automatic tick();
        logic [1:0] n_pend, n_di, n_de, n_run, n_blk;
        for (int c = 0; c < 2; c++) begin
            logic rise, clr;
            logic [7:0] sa, ca;
            sa   = (c == 0) ? 8'h72 : 8'h7A;
            ca   = (c == 0) ? 8'h70 : 8'h78;
            rise = irq_in[c] && !m_prev[c];
            clr  = wr_en && (((c == 0) && addr == 8'h50 && wdata[2]) ||
                             ((c == 1) && addr == 8'h57 && wdata[4]) ||
                             (addr == 8'h71 && wdata[2 + c]));
            n_pend[c] = rise ? 1'b1 : (clr ? 1'b0 : m_pend[c]);
            n_di[c]   = rise ? 1'b1 : ((wr_en && addr == sa && wdata[2]) ? 1'b0 : m_di[c]);
            n_de[c]   = err_in[c] ? 1'b1 : ((wr_en && addr == sa && wdata[1]) ? 1'b0 : m_de[c]);
            n_run[c]  = (wr_en && addr == ca) ? wdata[0] : m_run[c];
            n_blk[c]  = (wr_en && addr == 8'h71) ? wdata[4 + c] : m_blk[c];
        end
        if (wr_en && addr == 8'h50) m_cfg0 = wdata & 8'hFB;
        if (wr_en && addr == 8'h57) m_cfg1 = wdata & 8'hEF;
        m_prev = irq_in; m_pend = n_pend; m_di = n_di; m_de = n_de;
        m_run = n_run; m_blk = n_blk;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_all();
        logic [7:0] alist [8];
        alist = '{8'h50, 8'h57, 8'h71, 8'h70, 8'h72, 8'h78, 8'h7A, 8'h33};
        wr_en = 1'b0;
        chk("R6 irq_out", {7'b0, irq_out}, {7'b0, |(m_pend & ~m_blk)});
        chk("R9 src_hit", {7'b0, src_hit}, {7'b0, m_pend[chan_sel] & m_di[chan_sel]});
        chk("R8 dma_run", {6'b0, dma_run}, {6'b0, m_run});
        for (int i = 0; i < 8; i++) begin
            addr = alist[i];
            #1;
            chk(tag_of(alist[i]), rdata, exp_read(alist[i]));
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_all();
        chk("R1 irq_out", {7'b0, irq_out}, 8'h00);

        // R2, R3: channel 0 edge
        irq_in = 2'b01; tick(); check_all();
        addr = 8'h50; #1; chk("R3 cfg0 bit2", rdata & 8'h04, 8'h04);
        addr = 8'h71; #1; chk("R3 mirror bit2", rdata & 8'h04, 8'h04);
        addr = 8'h72; #1; chk("R2 status intr", rdata & 8'h04, 8'h04);
        // R5: clear through mirror while line still high; no re-set (R2)
        wr(8'h71, 8'h04); check_all();
        tick(); check_all();
        chk("R2 no retrigger", {7'b0, irq_out}, 8'h00);

        // R4: channel 1, zero-in-position write keeps the flag
        irq_in = 2'b11; tick();
        wr(8'h57, 8'hEF); check_all();
        addr = 8'h57; #1; chk("R4 keep", rdata, 8'hFF);
        wr(8'h57, 8'h10); check_all();
        addr = 8'h57; #1; chk("R4 clear", rdata & 8'h10, 8'h00);

        // R10: new edge and clear in same cycle
        irq_in = 2'b01; tick();
        irq_in = 2'b11; wr_en = 1'b1; addr = 8'h57; wdata = 8'h10; tick();
        check_all();
        addr = 8'h71; #1; chk("R10 set wins", rdata & 8'h08, 8'h08);

        // R6: blocking both
        wr(8'h71, 8'h30); check_all();
        chk("R6 blocked", {7'b0, irq_out}, 8'h00);
        // R9: select each channel
        chan_sel = 1'b1; #1; chk("R9 ch1 hit", {7'b0, src_hit}, 8'h01);
        wr(8'h7A, 8'h04); check_all();
        chk("R9 after intr clear", {7'b0, src_hit}, 8'h00);

        // R8: run then stop
        wr(8'h70, 8'h01); check_all();
        wr(8'h70, 8'h00); check_all();
        // R7: error set and clear
        err_in = 2'b10; tick(); err_in = 2'b00; check_all();
        wr(8'h7A, 8'h02); check_all();
        // R11: unmapped write
        wr(8'h33, 8'hFF); check_all();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] alist [8];
            alist = '{8'h50, 8'h57, 8'h71, 8'h70, 8'h72, 8'h78, 8'h7A, 8'h33};
            irq_in   = 2'($urandom);
            err_in   = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
            chan_sel = 1'($urandom);
            wr_en    = (($urandom % 2) == 0);
            addr     = alist[$urandom % 8];
            wdata    = 8'($urandom);
            tick();
            check_all();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule